// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Restart and One-Time Configuration

This block supervises software by counting down from a programmed start value on each pulse of a slow `tick` enable. Software has to issue a restart command while the count sits inside an allowed window near the bottom of its range. If the count runs out, the block flags an underflow and can pulse a reset request. A restart that comes too early, while the count is still above the window threshold, is flagged as an error instead. Either event can raise a level interrupt.

Software reaches the block through a small register bus. The configuration word can be written exactly once after reset, and that write also locks it. Every restart command has to carry a fixed 8-bit key in its top byte. Reading the status word returns the live count together with the lock state and the two event flags, and the same read clears both flags.

The sequencing is handled by a four-state machine:

- `ST_UNCFG` is the state after reset: no configuration has been written and the count is frozen.
- `ST_HALT` is entered when the configuration was written with the enable bit clear. The block is locked and the count stays frozen.
- `ST_RUN` is entered when the configuration was written with the enable bit set. The count runs and restarts are evaluated.
- `ST_FIRE` is a single cycle that follows an underflow. The reset request is asserted here.

The transitions are:

- "configure-run" (`ST_UNCFG` to `ST_RUN`)
- "configure-halt" (`ST_UNCFG` to `ST_HALT`)
- "expire" (`ST_RUN` to `ST_FIRE`)
- "resume" (`ST_FIRE` to `ST_RUN`, always after one cycle)

Top module: `wdt_window_guard`

## Requirements
- R1: After reset the status word reads 0, and `rst_req` and `irq` are both 0.
- R2: The first write to address 0 is accepted. The fields of that word are: start value in bits [15:0], window value in bits [27:16], enable in bit 28, reset enable in bit 29, underflow interrupt enable in bit 30 and error interrupt enable in bit 31. This write loads the count with the start value and sets the lock bit, which is status bit 2.
- R3: Once the lock bit is set, writes to address 0 change nothing until the next reset.
- R4: A write to address 1 is a restart only when bits [31:24] equal 0xA5 and bit 0 is 1. A write with any other key value changes neither the count nor the flags.
- R5: In `ST_RUN` each cycle with `tick` high decrements the count by one. When the configuration was written with enable 0, the count stays frozen.
- R6: The window threshold is {window, 4'hF}. A restart in `ST_RUN` while the count is at or below this threshold reloads the count with the start value.
- R7: A restart in `ST_RUN` while the count is above the threshold sets the error flag (status bit 1) and does not reload the count.
- R8: A tick in `ST_RUN` while the count is 0 sets the underflow flag (status bit 0), reloads the start value and enters `ST_FIRE`. In `ST_FIRE` the count holds.
- R9: `rst_req` is high for exactly the one `ST_FIRE` cycle, and only when reset enable is set.
- R10: `irq` equals (underflow AND its enable) OR (error AND its enable).
- R11: A read of address 2 returns the count in bits [31:16] and the lock, error and underflow flags in bits [2:0]. The same read clears the underflow and error flags on that clock edge. If a new event arrives in the same cycle, setting the flag wins over clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per timer step |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address: 0 = configuration, 1 = control, 2 = status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during the read cycle |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that `bus_we` and `bus_re` are never high in the same cycle. They also assume that a restart and a tick do not coincide while the count is already 0, so the underflow check always sees the plain expiry case. The stimulus keeps within these limits by issuing exactly one bus operation per cycle, always at the falling edge, and by never holding `tick` high during a bus access. Underflow, early restart, in-window restart and bad-key cases are each reached deliberately by counting ticks up to a known count.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        ST_UNCFG = 2'd0,
        ST_HALT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FIRE  = 2'd3
    } wdt_state_e;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;

endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned WIN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept,
    output logic              locked,
    output logic [CNT_W-1:0]  start_val,
    output logic [WIN_W-1:0]  win_val,
    output logic              run_en,
    output logic              rst_en,
    output logic              ie_uf,
    output logic              ie_err
);
    localparam int unsigned FLG_LSB = CNT_W + WIN_W;

    logic [DATA_W-1:0] cfg_q;
    logic              lock_q;

    assign accept = wr && !lock_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            lock_q <= 1'b0;
        end else if (accept) begin
            cfg_q  <= wdata;
            lock_q <= 1'b1;
        end
    end

    assign locked    = lock_q;
    assign start_val = cfg_q[CNT_W-1:0];
    assign win_val   = cfg_q[CNT_W +: WIN_W];
    assign run_en    = cfg_q[FLG_LSB];
    assign rst_en    = cfg_q[FLG_LSB+1];
    assign ie_uf     = cfg_q[FLG_LSB+2];
    assign ie_err    = cfg_q[FLG_LSB+3];

    generate
        if (DATA_W > FLG_LSB + 4) begin : g_spare
            logic unused_cfg_hi;
            assign unused_cfg_hi = ^cfg_q[DATA_W-1:FLG_LSB+4];
        end
    endgenerate

    // Enable bits feed the state machine directly from the word being written.
    logic unused_wdata_lo;
    assign unused_wdata_lo = ^wdata[FLG_LSB-1:0];

endmodule

// File: rtl/wdt_key_check.sv
module wdt_key_check #(
    parameter int unsigned          DATA_W = 32,
    parameter int unsigned          KEY_W  = 8,
    parameter logic [KEY_W-1:0]     KEY    = 8'hA5
) (
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              restart
);
    localparam int unsigned KEY_LSB = DATA_W - KEY_W;

    logic key_ok;

    assign key_ok  = (wdata[KEY_LSB +: KEY_W] == KEY);
    assign restart = wr && key_ok && wdata[0];

    logic unused_mid;
    assign unused_mid = ^wdata[KEY_LSB-1:1];

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned WIN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic [WIN_W-1:0] win,
    output logic [CNT_W-1:0] count,
    output logic             zero,
    output logic             in_window
);
    localparam int unsigned PAD_W = CNT_W - WIN_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr;

    assign thr = {win, {PAD_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count     = cnt_q;
    assign zero      = (cnt_q == '0);
    assign in_window = (cnt_q <= thr);

endmodule

// File: rtl/wdt_status_flags.sv
module wdt_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_uf,
    input  logic set_err,
    input  logic clr,
    output logic uf,
    output logic err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf  <= 1'b0;
            err <= 1'b0;
        end else begin
            if (set_uf) begin
                uf <= 1'b1;
            end else if (clr) begin
                uf <= 1'b0;
            end
            if (set_err) begin
                err <= 1'b1;
            end else if (clr) begin
                err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdt_window_guard.sv
module wdt_window_guard
    import wdt_guard_pkg::*;
#(
    parameter int unsigned      DATA_W = 32,
    parameter int unsigned      CNT_W  = 16,
    parameter int unsigned      WIN_W  = 12,
    parameter int unsigned      KEY_W  = 8,
    parameter logic [KEY_W-1:0] KEY    = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              irq
);
    localparam int unsigned FLG_LSB = CNT_W + WIN_W;
    localparam int unsigned GAP_W   = DATA_W - CNT_W - 3;

    wdt_state_e state_q, state_d;

    logic             cfg_wr, ctl_wr, stat_rd;
    logic             cfg_accept, locked;
    logic [CNT_W-1:0] start_val, count;
    logic [WIN_W-1:0] win_val;
    logic             run_en, rst_en, ie_uf, ie_err;
    logic             restart, zero, in_window;
    logic             in_run, rs_ok, rs_early, uf_evt;
    logic             cnt_load, cnt_dec;
    logic [CNT_W-1:0] cnt_load_val;
    logic             uf_flag, err_flag;

    assign cfg_wr  = bus_we && (bus_addr == ADR_CFG);
    assign ctl_wr  = bus_we && (bus_addr == ADR_CTL);
    assign stat_rd = bus_re && (bus_addr == ADR_STAT);

    wdt_cfg_lock #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .WIN_W  (WIN_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wdata     (bus_wdata),
        .accept    (cfg_accept),
        .locked    (locked),
        .start_val (start_val),
        .win_val   (win_val),
        .run_en    (run_en),
        .rst_en    (rst_en),
        .ie_uf     (ie_uf),
        .ie_err    (ie_err)
    );

    wdt_key_check #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .KEY    (KEY)
    ) u_key (
        .wr      (ctl_wr),
        .wdata   (bus_wdata),
        .restart (restart)
    );

    // Event decode, evaluated only while running
    assign in_run   = (state_q == ST_RUN);
    assign rs_ok    = in_run && restart && in_window;
    assign rs_early = in_run && restart && !in_window;
    assign uf_evt   = in_run && tick && zero && !rs_ok;

    // Counter control: configuration, in-window restart and expiry all reload
    assign cnt_load     = cfg_accept || rs_ok || uf_evt;
    assign cnt_load_val = cfg_accept ? bus_wdata[CNT_W-1:0] : start_val;
    assign cnt_dec      = in_run && tick && !zero;

    wdt_down_counter #(
        .CNT_W (CNT_W),
        .WIN_W (WIN_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (cnt_load_val),
        .dec       (cnt_dec),
        .win       (win_val),
        .count     (count),
        .zero      (zero),
        .in_window (in_window)
    );

    wdt_status_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_uf  (uf_evt),
        .set_err (rs_early),
        .clr     (stat_rd),
        .uf      (uf_flag),
        .err     (err_flag)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNCFG;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNCFG: begin
                if (cfg_accept) begin
                    state_d = bus_wdata[FLG_LSB] ? ST_RUN : ST_HALT;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            ST_RUN: begin
                if (uf_evt) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_UNCFG;
            end
        endcase
    end

    // Outputs
    always_comb begin
        rst_req   = (state_q == ST_FIRE) && rst_en;
        irq       = (uf_flag && ie_uf) || (err_flag && ie_err);
        bus_rdata = '0;
        if (stat_rd) begin
            bus_rdata = {count, {GAP_W{1'b0}}, locked, err_flag, uf_flag};
        end
    end

    logic unused_cfg;
    assign unused_cfg = run_en;

endmodule

// File: rtl/wdt_guard_checker.sv
module wdt_guard_checker
    import wdt_guard_pkg::*;
#(
    parameter int unsigned      DATA_W = 32,
    parameter int unsigned      CNT_W  = 16,
    parameter int unsigned      WIN_W  = 12,
    parameter int unsigned      KEY_W  = 8,
    parameter logic [KEY_W-1:0] KEY    = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rst_req,
    input wdt_state_e        state_q,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  start_val,
    input logic [WIN_W-1:0]  win_val,
    input logic              locked,
    input logic              uf_flag,
    input logic              err_flag
);
    logic [CNT_W-1:0] c_thr;
    logic             c_good, c_bad;

    assign c_thr  = {win_val, {(CNT_W-WIN_W){1'b1}}};
    assign c_good = bus_we && bus_addr == ADR_CTL
                    && bus_wdata[DATA_W-1 -: KEY_W] == KEY && bus_wdata[0];
    assign c_bad  = bus_we && bus_addr == ADR_CTL
                    && bus_wdata[DATA_W-1 -: KEY_W] != KEY;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(start_val) && $stable(win_val) && locked); // R3
    AST_BADKEY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        c_bad && !tick |=> count == $past(count)); // R4
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALT |=> $stable(count)); // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN && c_good && count <= c_thr |=> count == $past(start_val)); // R6
    AST_EARLY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN && c_good && count > c_thr |=> err_flag); // R7
    AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN && tick && count == '0 && !c_good |=> uf_flag && state_q == ST_FIRE); // R8
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R9

endmodule

bind wdt_window_guard wdt_guard_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WIN_W  (WIN_W),
    .KEY_W  (KEY_W),
    .KEY    (KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rst_req   (rst_req),
    .state_q   (state_q),
    .count     (count),
    .start_val (start_val),
    .win_val   (win_val),
    .locked    (locked),
    .uf_flag   (uf_flag),
    .err_flag  (err_flag)
);

// File: tb/sim_wdt_window_guard.sv
module sim_wdt_window_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdt_window_guard u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .irq       (irq)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 cfg, 1 ctl, 2 read, 3 tick burst
        logic [31:0] data;
        logic [31:0] exp;
        logic        irq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 32'h0,        32'h0000_0000, 1'b0}, // R1
        '{2'd0, 32'hF002_0040, 32'h0,        1'b0}, // R2
        '{2'd2, 32'h0,        32'h0040_0004, 1'b0}, // R2
        '{2'd0, 32'h0000_0010, 32'h0,        1'b0}, // R3
        '{2'd2, 32'h0,        32'h0040_0004, 1'b0}, // R3
        '{2'd3, 32'd10,       32'h0,         1'b0}, // R5
        '{2'd2, 32'h0,        32'h0036_0004, 1'b0}, // R5
        '{2'd1, 32'h1200_0001, 32'h0,        1'b0}, // R4
        '{2'd2, 32'h0,        32'h0036_0004, 1'b0}, // R4
        '{2'd1, 32'hA500_0001, 32'h0,        1'b1}, // R7 R10
        '{2'd2, 32'h0,        32'h0036_0006, 1'b0}, // R7 R11
        '{2'd2, 32'h0,        32'h0036_0004, 1'b0}, // R11
        '{2'd3, 32'd7,        32'h0,         1'b0}, // R5
        '{2'd1, 32'hA500_0001, 32'h0,        1'b0}, // R6
        '{2'd2, 32'h0,        32'h0040_0004, 1'b0}, // R6
        '{2'd1, 32'hA500_0000, 32'h0,        1'b0}, // R4
        '{2'd2, 32'h0,        32'h0040_0004, 1'b0}, // R4
        '{2'd3, 32'd65,       32'h0,         1'b1}, // R8 R10
        '{2'd2, 32'h0,        32'h0040_0005, 1'b0}, // R8 R11
        '{2'd2, 32'h0,        32'h0040_0004, 1'b0}  // R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_rd(input string req, input logic [31:0] exp);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = 2'd2;
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic do_tick(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                2'd0: do_wr(2'd0, VEC[i].data);
                2'd1: do_wr(2'd1, VEC[i].data);
                2'd2: do_rd($sformatf("vec%0d R11/status", i), VEC[i].exp);
                default: do_tick(int'(VEC[i].data));
            endcase
            chk($sformatf("vec%0d R10 irq", i), {31'd0, irq}, {31'd0, VEC[i].irq});
        end

        // Reset unlocks; reset pulse on expiry (R1, R3, R9)
        do_reset();
        do_rd("R1 status after reset", 32'h0);
        do_wr(2'd0, 32'h3FFF_0003);
        do_rd("R2 reconfig after reset", 32'h0003_0004);
        do_tick(3);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R9 rst_req high", {31'd0, rst_req}, 32'd1);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R9 rst_req one cycle", {31'd0, rst_req}, 32'd0);
        do_rd("R8 uf and reload", 32'h0003_0005);

        // Early restart with its interrupt disabled (R7, R10)
        do_reset();
        do_wr(2'd0, 32'h1000_0020);
        do_wr(2'd1, 32'hA500_0001);
        chk("R10 err irq masked", {31'd0, irq}, 32'd0);
        do_rd("R7 err no reload", 32'h0020_0006);

        // Halted configuration keeps the count (R5)
        do_reset();
        do_wr(2'd0, 32'h0000_0020);
        do_tick(5);
        do_wr(2'd1, 32'hA500_0001);
        do_rd("R5 halted count frozen", 32'h0020_0004);
        chk("R9 no rst_req when halted", {31'd0, rst_req}, 32'd0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule